// File: doc/BRIEF.md
# Power-On Strap Sampling Controller

This block manages a group of dual-role pins that act as configuration inputs straight after power-up and then become clock outputs. When the power-on reset is released, a settling window of a fixed length starts. For that whole window every pin driver stays in high impedance, so the external pull resistors set the pin levels. On the last cycle of the window the controller captures the synchronized level of every pin. One cycle later it enables all the output drivers together and raises a completion flag.

The captured bits are the configuration for the rest of the chip. Four of them select the frequency and one selects the mode. The mode bit decides whether a separate shared pin drives the reference clock or stays an input that stops the bus clocks. Only a new power-on reset clears the captured bits and starts the window again. Pin activity at any other time has no effect on them.

Top module: `strap_capture_top`

## Requirements
- R1: While `por_n` is low, `pad_oe` is all zeros, `shared_oe` is 0, `done` is 0 and `strap_bits` is all zeros.
- R2: After `por_n` is released, `done` stays 0 for exactly WINDOW rising edges and becomes 1 after edge WINDOW+1. While `done` is 0, `pad_oe` and `shared_oe` are 0.
- R3: The value captured for each pin is that pin's level as seen through a two-flop synchronizer at edge WINDOW. A pin change made between edge WINDOW-3 and edge WINDOW-2 is captured. A change made between edge WINDOW-2 and edge WINDOW-1 is not captured.
- R4: The drivers are enabled only in the cycle after the capture. All bits of `pad_oe` go high together, and they stay high for as long as `done` is 1.
- R5: Once `done` is 1, `strap_bits` and `done` do not change, whatever the pins do, until `por_n` is asserted again.
- R6: Field map: `freq_sel` = `strap_bits[3:0]` and `mode_sel` = `strap_bits[4]`, where a captured low level is 0 and a captured high level is 1. `shared_oe` is 1 only when `done` is 1 and `mode_sel` is 1. When `mode_sel` is 1 the shared pin drives the reference clock; when it is 0 the shared pin is the stop input.
- R7: Asserting `por_n` again at any time clears the block. A new window then runs and captures the pin levels that are present at that moment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous assert |
| pad_in | input | NUM_PINS | Levels sensed on the dual-role pins |
| pad_oe | output | NUM_PINS | Output driver enables for the dual-role pins |
| shared_oe | output | 1 | Driver enable for the shared reference/stop pin |
| strap_bits | output | NUM_PINS | Captured strap values |
| freq_sel | output | FSEL_BITS | Frequency select field |
| mode_sel | output | 1 | Mode select bit |
| done | output | 1 | Capture complete; stays high until the next power-on reset |

## Verification
The bench steps through all 32 strap patterns, each with its own power cycle. In every cycle it checks the exact edge at which `done` rises and confirms that the drivers stay off until then. A counter that is one cycle off would light the drivers early or late, and a capture made after the drivers are on would record the block's own output instead of the strap. The bench also changes a pin on either side of the synchronizer's two-cycle latency, which exposes a design that samples the raw pin or the wrong flop. After completion the pins are toggled and the reset is asserted again in the middle of a window, which exposes latches that can be overwritten or that are not cleared.

// File: rtl/strap_pkg.sv
package strap_pkg;
  // Width of a counter that has to reach n-1.
  function automatic int cnt_width(input int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

  // Pin index of the mode strap; the indices below it hold the frequency select.
  function automatic int mode_index(input int fsel_bits);
    return fsel_bits;
  endfunction
endpackage

// File: rtl/strap_sync.sv
module strap_sync #(
  parameter int WIDTH = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= 1'b0;
        s2 <= 1'b0;
      end else begin
        s1 <= d[i];
        s2 <= s1;
      end
    end
    assign q[i] = s2;
  end
endmodule

// File: rtl/strap_window_timer.sv
module strap_window_timer #(
  parameter int WINDOW = 28636
) (
  input  logic clk,
  input  logic rst_n,
  output logic tc
);
  import strap_pkg::*;
  localparam int CW = cnt_width(WINDOW);
  localparam logic [CW-1:0] LAST = CW'(WINDOW - 1);

  logic [CW-1:0] cnt;
  logic          expired;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      expired <= 1'b0;
    end else if (!expired) begin
      if (cnt == LAST) expired <= 1'b1;
      else             cnt     <= cnt + 1'b1;
    end
  end

  assign tc = !expired && (cnt == LAST);

  a_r2_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);
  a_r2_tc_single: assert property (@(posedge clk) disable iff (!rst_n)
    tc |=> !tc);
  a_r2_expired_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    expired |=> expired);
endmodule

// File: rtl/strap_latch.sv
module strap_latch #(
  parameter int WIDTH = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tc,
  input  logic [WIDTH-1:0] pin_sync,
  output logic [WIDTH-1:0] strap,
  output logic             captured,
  output logic             done
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strap    <= '0;
      captured <= 1'b0;
      done     <= 1'b0;
    end else begin
      if (tc) begin
        strap    <= pin_sync;
        captured <= 1'b1;
      end
      if (captured) done <= 1'b1;
    end
  end

  a_r5_strap_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    captured |=> $stable(strap));
  a_r4_done_after_capture: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(captured));
  a_r5_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);
  a_r3_capture_on_tc: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(captured) |-> $past(tc));
endmodule

// File: rtl/strap_capture_top.sv
module strap_capture_top #(
  parameter int NUM_PINS  = 5,
  parameter int FSEL_BITS = 4,
  parameter int WINDOW    = 28636
) (
  input  logic                 clk_ref,
  input  logic                 por_n,
  input  logic [NUM_PINS-1:0]  pad_in,
  output logic [NUM_PINS-1:0]  pad_oe,
  output logic                 shared_oe,
  output logic [NUM_PINS-1:0]  strap_bits,
  output logic [FSEL_BITS-1:0] freq_sel,
  output logic                 mode_sel,
  output logic                 done
);
  import strap_pkg::*;
  localparam int MODE_IDX = mode_index(FSEL_BITS);

  logic [NUM_PINS-1:0] pin_sync;
  logic                tc_evt;
  logic                capture_evt;

  strap_sync #(.WIDTH(NUM_PINS)) i_sync (
    .clk(clk_ref), .rst_n(por_n), .d(pad_in), .q(pin_sync));

  strap_window_timer #(.WINDOW(WINDOW)) i_timer (
    .clk(clk_ref), .rst_n(por_n), .tc(tc_evt));

  strap_latch #(.WIDTH(NUM_PINS)) i_latch (
    .clk(clk_ref), .rst_n(por_n), .tc(tc_evt), .pin_sync(pin_sync),
    .strap(strap_bits), .captured(capture_evt), .done(done));

  assign pad_oe    = {NUM_PINS{done}};
  assign freq_sel  = strap_bits[FSEL_BITS-1:0];
  assign mode_sel  = strap_bits[MODE_IDX];
  assign shared_oe = done & mode_sel;

  a_r2_quiet_in_window: assert property (@(posedge clk_ref) disable iff (!por_n)
    !capture_evt |-> (pad_oe == '0 && !shared_oe));
  a_r4_oe_after_capture: assert property (@(posedge clk_ref) disable iff (!por_n)
    $rose(pad_oe[0]) |-> $past(capture_evt));
  a_r6_shared_needs_done: assert property (@(posedge clk_ref) disable iff (!por_n)
    shared_oe |-> done);
endmodule

// File: tb/test_strap_capture_top.sv
module test_strap_capture_top;
  localparam int N = 5;
  localparam int W = 20;

  logic clk_ref = 1'b0;
  logic por_n   = 1'b0;
  logic [N-1:0] pad_in = '0;
  logic [N-1:0] pad_oe, strap_bits;
  logic [3:0]   freq_sel;
  logic         shared_oe, mode_sel, done;
  int total = 0, bad = 0;
  bit finished = 0;

  strap_capture_top #(.NUM_PINS(N), .FSEL_BITS(4), .WINDOW(W)) i_strap_capture_top (
    .clk_ref(clk_ref), .por_n(por_n), .pad_in(pad_in), .pad_oe(pad_oe),
    .shared_oe(shared_oe), .strap_bits(strap_bits), .freq_sel(freq_sel),
    .mode_sel(mode_sel), .done(done));

  always #5 clk_ref = ~clk_ref;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Returns at a negedge just after release; edge k after return is edge k.
  task automatic power_cycle(input logic [N-1:0] v);
    @(negedge clk_ref);
    por_n = 1'b0;
    pad_in = v;
    repeat (2) @(negedge clk_ref);
    chk("R1 oe", 32'(pad_oe), 0);
    chk("R1 done", 32'(done), 0);
    chk("R1 strap", 32'(strap_bits), 0);
    chk("R1 shared", 32'(shared_oe), 0);
    por_n = 1'b1;
  endtask

  task automatic edges(input int n);
    repeat (n) @(negedge clk_ref);
  endtask

  task automatic check_result(input logic [N-1:0] v, input string tag);
    chk({tag, " R6 strap"}, 32'(strap_bits), 32'(v));
    chk({tag, " R6 fsel"}, 32'(freq_sel), 32'(v[3:0]));
    chk({tag, " R6 mode"}, 32'(mode_sel), 32'(v[4]));
    chk({tag, " R6 shared"}, 32'(shared_oe), 32'(v[4]));
    chk({tag, " R4 oe"}, 32'(pad_oe), 32'({N{1'b1}}));
  endtask

  initial begin
    // Sweep of all strap patterns.
    for (int p = 0; p < 32; p++) begin
      logic [N-1:0] v = N'(p);
      int early = 0;
      power_cycle(v);
      for (int k = 1; k <= W; k++) begin
        edges(1);
        if (done !== 1'b0 || pad_oe !== '0 || shared_oe !== 1'b0) early++;
      end
      chk("R2 quiet through edge W", 32'(early), 0);
      edges(1);
      chk("R2 done at W+1", 32'(done), 1);
      check_result(v, "sweep");
      // R5: toggle pins after completion.
      pad_in = ~v;
      edges(4);
      pad_in = N'(p * 7);
      edges(3);
      chk("R5 strap frozen", 32'(strap_bits), 32'(v));
      chk("R5 done held", 32'(done), 1);
    end

    // R3: change captured when made after edge W-3.
    power_cycle(5'b00000);
    edges(W - 3);
    pad_in = 5'b10110;
    edges(4);
    check_result(5'b10110, "R3 late-in");
    // R3: change missed when made after edge W-2.
    power_cycle(5'b01001);
    edges(W - 2);
    pad_in = 5'b10110;
    edges(3);
    check_result(5'b01001, "R3 too-late");

    // R7: reset asserted again mid-window, then a new pattern is captured.
    power_cycle(5'b11111);
    edges(W / 2);
    power_cycle(5'b00110);
    edges(W);
    chk("R7 not done at W", 32'(done), 0);
    edges(1);
    check_result(5'b00110, "R7");
    // R7: reset asserted again after done, clears and recaptures.
    power_cycle(5'b10001);
    edges(W + 1);
    check_result(5'b10001, "R7 repeat");

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_ref);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule